// File: doc/BRIEF.md
# JTAG Scan Chain Enumerator

This block is the host side of a JTAG link that finds out what sits on a scan chain. It generates TCK from the system clock through a programmable half-period divider, drives TMS and TDI, and samples TDO. TDO is its only input from the chain. A start pulse makes it put every TAP in the chain into Test-Logic-Reset. After that reset each TAP exposes either its 1-bit bypass register or its 32-bit identification register. The engine then walks the TAPs into Shift-DR.

In Shift-DR the engine feeds ones into TDI and reads the stream that comes out of TDO. A 0 bit is a bypass-only device. A 1 bit is the first bit of a 32-bit identification word. A word that is all ones is the engine's own fill coming back, which means the chain has ended. Each identification word leaves through a valid/ready stream together with its position on the chain. At the end the engine steps the TAPs to Run-Test/Idle and pulses `done` with the number of devices it found. If the fill never comes back within `MAX_DEV` devices, the engine stops and flags an error.

The result stream follows valid/ready rules. `id_valid` rises with a word and stays high, with `id_word` and `id_pos` unchanged, until the cycle in which `id_ready` is high. While a word waits, the engine freezes TCK, so the chain never runs ahead of the consumer and no word is dropped.

Top module: `jtag_chain_enum`

## Requirements
- R1: After reset, TCK is 0, TMS is 1, TDI is 1, `id_valid`, `done` and `err` are 0, and `dev_count` is 0.
- R2: After `start`, the first five TCK rising edges see TMS = 1 and the next four see TMS = 0, 1, 0, 0, which leaves every TAP in Shift-DR.
- R3: While running and not stalled, every TCK high phase and low phase lasts `half_period` system clocks, with values below 2 treated as 2.
- R4: TMS changes only in the cycle in which TCK falls, or in the cycle after an accepted `start`. TDI is held at 1 for the whole enumeration.
- R5: In Shift-DR, a TDO bit of 0 at the start of a device counts one bypass device and produces no stream word.
- R6: In Shift-DR, a TDO bit of 1 at the start of a device begins a 32-bit word, first bit in the LSB. A word that is not all ones counts one device and is sent on the stream, with `id_pos` giving the zero-based device index counted from the TDO end.
- R7: A 32-bit word of all ones ends the scan. The next three rising edges see TMS = 1, 1, 0, so the TAPs go to Run-Test/Idle. At the following TCK fall, `done` is high for exactly one cycle with TCK low, and `dev_count` then holds the number of devices.
- R8: If a device starts while `dev_count` already equals `MAX_DEV`, the scan ends through the same exit as R7. `done` pulses with `err` = 1 and `dev_count` = `MAX_DEV`. `err` is cleared by the next accepted `start`.
- R9: While `id_valid` is high and `id_ready` is low, `id_valid`, `id_word`, `id_pos` and TCK all hold their values.
- R10: A `start` pulse during an enumeration is ignored: that enumeration produces exactly one `done` and its normal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to enumerate the chain |
| half_period | input | DIV_W | TCK half-period in system clocks (minimum 2) |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Serial data into the chain |
| tdo | input | 1 | Serial data out of the chain |
| id_valid | output | 1 | Identification word available |
| id_ready | input | 1 | Consumer accepts the word in this cycle |
| id_word | output | 32 | Identification word, first shifted bit in bit 0 |
| id_pos | output | CNT_W | Device index of the word, 0 nearest TDO |
| done | output | 1 | One-cycle pulse at the end of an enumeration |
| err | output | 1 | Set with `done` when the device limit was hit |
| dev_count | output | CNT_W | Devices found so far, final value after `done` |

## Verification
The assertions check every cycle for several properties. A TCK level always lasts at least two system clocks. TMS moves only on a falling TCK or right after a start. A pending word, its position and TCK stay frozen under back-pressure. `done` is a single cycle and arrives with TCK low. The count never passes its limit. Every emitted word begins with a 1 bit. The bench scenarios, run against a bit-accurate chain model, are needed for the rest. They cover the exact TMS walk into and out of Shift-DR, the parsing of mixed bypass and identification chains (including an empty chain and a word that is all ones except its top bit), the positions reported, the exact divider widths, the limit error with a stuck TDO, and a start pulse arriving mid-scan.

// File: rtl/jce_pkg.sv
package jce_pkg;

  localparam int ID_W = 32;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_GOTO,
    PH_SHIFT,
    PH_EXIT
  } phase_t;

endpackage

// File: rtl/jce_tck_gen.sv
module jce_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt;
  logic             toggle;

  assign half_eff = (half_i < MIN_HALF) ? MIN_HALF : half_i;
  assign toggle   = run_i && !hold_i && (cnt >= half_eff - DIV_W'(1));
  assign rise_o   = toggle && !tck_o;
  assign fall_o   = toggle && tck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_o <= 1'b0;
      cnt   <= '0;
    end else if (!run_i) begin
      tck_o <= 1'b0;
      cnt   <= '0;
    end else if (!hold_i) begin
      if (toggle) begin
        cnt   <= '0;
        tck_o <= ~tck_o;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R3: no TCK level is ever shorter than two system clocks
  a_r3_min_level: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_o != $past(tck_o)) |=> $stable(tck_o));

endmodule

// File: rtl/jce_chain_parser.sv
module jce_chain_parser
  import jce_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            bit_en_i,
  input  logic            bit_i,
  output logic            byp_o,
  output logic            id_o,
  output logic            mark_o,
  output logic [ID_W-1:0] word_o
);

  localparam int CW = $clog2(ID_W);
  localparam logic [CW-1:0] LAST = CW'(ID_W - 1);

  logic            in_word;
  logic [CW-1:0]   cnt;
  logic [ID_W-2:0] sh;
  logic            last_bit;

  assign word_o   = {bit_i, sh};
  assign last_bit = bit_en_i && in_word && (cnt == LAST);
  assign byp_o    = bit_en_i && !in_word && !bit_i;
  assign id_o     = last_bit && !(&word_o);
  assign mark_o   = last_bit && (&word_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_word <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
    end else if (clr_i) begin
      in_word <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
    end else if (bit_en_i) begin
      sh <= {bit_i, sh[ID_W-2:1]};
      if (!in_word) begin
        if (bit_i) begin
          in_word <= 1'b1;
          cnt     <= CW'(1);
        end
      end else if (cnt == LAST) begin
        in_word <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R6: a completed identification word always began with a 1 bit
  a_r6_word_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    id_o |-> word_o[0]);

endmodule

// File: rtl/jtag_chain_enum.sv
module jtag_chain_enum
  import jce_pkg::*;
#(
  parameter int MAX_DEV = 16,
  parameter int DIV_W   = 8,
  localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_period,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic             id_valid,
  input  logic             id_ready,
  output logic [ID_W-1:0]  id_word,
  output logic [CNT_W-1:0] id_pos,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] dev_count
);

  localparam logic [2:0]       RESET_LAST = 3'd4;
  localparam logic [2:0]       GOTO_LAST  = 3'd3;
  localparam logic [2:0]       EXIT_LAST  = 3'd3;
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(MAX_DEV);

  phase_t          phase;
  logic [2:0]      step;
  logic            busy;
  logic            launch;
  logic            stall;
  logic            rise;
  logic            fall;
  logic            tms_sel;
  logic            byp_ev;
  logic            id_ev;
  logic            mark_ev;
  logic [ID_W-1:0] word;
  logic            at_max;

  assign busy   = (phase != PH_IDLE);
  assign launch = start && !busy;
  assign stall  = id_valid && !id_ready;
  assign at_max = (dev_count == CNT_MAX);
  assign tdi    = 1'b1;

  jce_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .hold_i (stall),
    .half_i (half_period),
    .tck_o  (tck),
    .rise_o (rise),
    .fall_o (fall)
  );

  jce_chain_parser u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (launch),
    .bit_en_i (rise && (phase == PH_SHIFT)),
    .bit_i    (tdo),
    .byp_o    (byp_ev),
    .id_o     (id_ev),
    .mark_o   (mark_ev),
    .word_o   (word)
  );

  // TMS level presented for the next rising edge, driven at the falling edge
  always_comb begin
    unique case (phase)
      PH_RESET: tms_sel = 1'b1;
      PH_GOTO:  tms_sel = (step == 3'd1);
      PH_SHIFT: tms_sel = 1'b0;
      PH_EXIT:  tms_sel = (step < 3'd2);
      default:  tms_sel = tms;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      step      <= '0;
      tms       <= 1'b1;
      dev_count <= '0;
      err       <= 1'b0;
      done      <= 1'b0;
      id_valid  <= 1'b0;
      id_word   <= '0;
      id_pos    <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        phase     <= PH_RESET;
        step      <= '0;
        tms       <= 1'b1;
        dev_count <= '0;
        err       <= 1'b0;
      end else if (busy) begin
        if (id_valid && id_ready) id_valid <= 1'b0;
        if (rise) begin
          unique case (phase)
            PH_RESET: begin
              if (step == RESET_LAST) begin
                phase <= PH_GOTO;
                step  <= '0;
              end else step <= step + 3'd1;
            end
            PH_GOTO: begin
              if (step == GOTO_LAST) begin
                phase <= PH_SHIFT;
                step  <= '0;
              end else step <= step + 3'd1;
            end
            PH_SHIFT: begin
              if (mark_ev) begin
                phase <= PH_EXIT;
                step  <= '0;
              end else if (byp_ev || id_ev) begin
                if (at_max) begin
                  err   <= 1'b1;
                  phase <= PH_EXIT;
                  step  <= '0;
                end else begin
                  dev_count <= dev_count + CNT_W'(1);
                  if (id_ev) begin
                    id_valid <= 1'b1;
                    id_word  <= word;
                    id_pos   <= dev_count;
                  end
                end
              end
            end
            PH_EXIT: begin
              if (step < EXIT_LAST) step <= step + 3'd1;
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (phase == PH_EXIT && step == EXIT_LAST) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            tms <= tms_sel;
          end
        end
      end
    end
  end

  // R4: TMS only moves on a falling TCK or right after an accepted start
  a_r4_tms_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> (($past(tck) && !tck) || $past(launch)));

  // R9: a waiting word and TCK stay frozen under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready) |=>
      (id_valid && $stable(id_word) && $stable(id_pos) && $stable(tck)));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done arrives with TCK low
  a_r7_done_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tck);

  // R8: the device count never passes its limit
  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    dev_count <= CNT_MAX);

endmodule

// File: tb/jtag_chain_enum_bench.sv
module jtag_chain_enum_bench;

  localparam int MAXD = 16;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int NV   = 5;

  // four 32-bit slots per row, slot 0 nearest TDO; a zero slot is a bypass device
  localparam logic [127:0] V_IDS [NV] = '{
    {32'h0,        32'h0, 32'h0,        32'h1BA00477},
    {32'h0,        32'h0, 32'h0362D093, 32'h0},
    {32'h7FFFFFFF, 32'h0, 32'h0ABCDEF1, 32'h12345679},
    {32'h0,        32'h0, 32'h0,        32'h0},
    {32'h0,        32'h0, 32'h0,        32'h0}
  };
  localparam int V_N   [NV] = '{1, 3, 4, 2, 0};
  localparam int V_DIV [NV] = '{2, 3, 0, 5, 1};
  localparam bit V_STL [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, start, tdo, id_ready;
  logic [7:0]     half;
  logic           tck, tms, tdi, id_valid, done, err;
  logic [31:0]    id_word;
  logic [CW-1:0]  id_pos, dev_count;

  jtag_chain_enum #(.MAX_DEV(MAXD), .DIV_W(8)) u_jtag_chain_enum (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .id_valid(id_valid), .id_ready(id_ready), .id_word(id_word), .id_pos(id_pos),
    .done(done), .err(err), .dev_count(dev_count)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- chain model ----------------
  int            tap_st = 0;
  logic [1023:0] chain;
  int            chain_len = 0;
  logic [127:0]  cur_ids;
  int            cur_n = 0;
  bit            force0 = 1'b0;
  int            ld_pos;
  logic [8:0]    first9;
  logic [2:0]    last3;
  int            rise_idx, tdi_low;

  function automatic int tap_next(input int s, input logic m);
    case (s)
      0:  return m ? 0 : 1;
      1:  return m ? 2 : 1;
      2:  return m ? 9 : 3;
      3:  return m ? 5 : 4;
      4:  return m ? 5 : 4;
      5:  return m ? 8 : 6;
      6:  return m ? 7 : 6;
      7:  return m ? 8 : 4;
      8:  return m ? 2 : 1;
      9:  return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck) begin
    if (tap_st == 3) begin
      ld_pos = 0;
      for (int d = 0; d < cur_n; d++) begin
        if (cur_ids[32*d +: 32] == 32'h0) begin
          chain[ld_pos] = 1'b0;
          ld_pos++;
        end else begin
          for (int b = 0; b < 32; b++) chain[ld_pos + b] = cur_ids[32*d + b];
          ld_pos += 32;
        end
      end
      chain_len = ld_pos;
    end else if (tap_st == 4 && chain_len > 0) begin
      for (int i = 0; i < chain_len - 1; i++) chain[i] = chain[i+1];
      chain[chain_len-1] = tdi;
    end
    tap_st = tap_next(tap_st, tms);
    if (rise_idx < 9) first9 = {first9[7:0], tms};
    last3 = {last3[1:0], tms};
    rise_idx++;
    if (!tdi) tdi_low++;
  end

  initial tdo = 1'b1;
  always @(negedge tck) begin
    if (force0) tdo = 1'b0;
    else if (tap_st == 4) tdo = (chain_len == 0) ? tdi : chain[0];
  end

  // ---------------- port monitor and consumer ----------------
  bit          stall_mode = 1'b0;
  int          wait_cnt = 0, rx_n = 0, done_n = 0, stall_bad = 0;
  logic [31:0] rx_word [8];
  int          rx_pos  [8];
  int          got_cnt, got_err;
  int          hi = 0, hmin = 1000, hmax = 0;
  bit          prev_stall = 1'b0;
  logic        prev_tck = 1'b0;
  logic        tms_prev = 1'b1, tck_prev2 = 1'b0;
  int          tms_mid_bad = 0;

  always @(negedge clk) begin
    if (prev_stall && tck !== prev_tck) stall_bad++;
    if (!stall_mode) id_ready = 1'b1;
    else if (id_valid && !id_ready) begin
      wait_cnt++;
      if (wait_cnt >= 20) id_ready = 1'b1;
    end else if (!id_valid) begin
      id_ready = 1'b0;
      wait_cnt = 0;
    end
    if (id_valid && id_ready && rx_n < 8) begin
      rx_word[rx_n] = id_word;
      rx_pos[rx_n]  = int'(id_pos);
      rx_n++;
    end
    prev_stall = id_valid && !id_ready;
    prev_tck   = tck;
    if (done) begin
      done_n++;
      got_cnt = int'(dev_count);
      got_err = int'(err);
    end
    if (tms !== tms_prev && tck && tck_prev2) tms_mid_bad++;
    tms_prev  = tms;
    tck_prev2 = tck;
    if (tck) hi++;
    else if (hi > 0) begin
      if (hi < hmin) hmin = hi;
      if (hi > hmax) hmax = hi;
      hi = 0;
    end
  end

  int run_d0;

  task automatic run(input logic [127:0] ids, input int n, input int div, input bit stl, input bit poke);
    @(negedge clk);
    cur_ids = ids; cur_n = n; half = 8'(div); stall_mode = stl;
    rx_n = 0; rise_idx = 0; first9 = '0; last3 = '0;
    hmin = 1000; hmax = 0; tdi_low = 0; stall_bad = 0; tms_mid_bad = 0;
    run_d0 = done_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && done_n == run_d0; i++) begin
      @(negedge clk);
      start = (poke && i == 100);
    end
    start = 1'b0;
    check(done_n != run_d0, "R7 done reached", done_n, run_d0 + 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; half = 8'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tck == 1'b0 && tms == 1'b1 && tdi == 1'b1, "R1 pins", {tck, tms, tdi}, 3'b011);
    check(!id_valid && !done && !err, "R1 flags", {id_valid, done, err}, 0);
    check(dev_count == 0, "R1 count", dev_count, 0);

    for (int v = 0; v < NV; v++) begin
      int k;
      int eff;
      run(V_IDS[v], V_N[v], V_DIV[v], V_STL[v], 1'b0);
      check(first9 == 9'b111110100, "R2 tms walk", first9, 9'b111110100);
      check(tdi_low == 0 && tms_mid_bad == 0, "R4 tdi and tms timing", tdi_low + tms_mid_bad, 0);
      check(got_cnt == V_N[v] && got_err == 0, "R5 R6 device count", got_cnt, V_N[v]);
      check(last3 == 3'b110 && tap_st == 1, "R7 exit to idle", {last3, 4'(tap_st)}, {3'b110, 4'd1});
      k = 0;
      for (int d = 0; d < V_N[v]; d++) begin
        if (V_IDS[v][32*d +: 32] != 32'h0) begin
          check(k < rx_n && rx_word[k] == V_IDS[v][32*d +: 32], "R6 id word", rx_word[k], V_IDS[v][32*d +: 32]);
          check(rx_pos[k] == d, "R6 id position", rx_pos[k], d);
          k++;
        end
      end
      check(rx_n == k, "R5 no word for bypass", rx_n, k);
      if (V_STL[v]) check(stall_bad == 0, "R9 tck frozen while waiting", stall_bad, 0);
      else begin
        eff = (V_DIV[v] < 2) ? 2 : V_DIV[v];
        check(hmin == eff && hmax == eff, "R3 half period", {16'(hmin), 16'(hmax)}, {16'(eff), 16'(eff)});
      end
    end

    // R8: stuck-low TDO looks like endless bypass devices
    force0 = 1'b1;
    run(128'h0, 0, 2, 1'b0, 1'b0);
    force0 = 1'b0;
    check(got_err == 1, "R8 error flag", got_err, 1);
    check(got_cnt == MAXD, "R8 count at limit", got_cnt, MAXD);
    check(rx_n == 0 && tap_st == 1, "R8 no words, idle", rx_n + tap_st, 1);

    // R10: start during a scan is ignored; R8: err clears on the next start
    run(V_IDS[2], V_N[2], 2, 1'b0, 1'b1);
    repeat (300) @(negedge clk);
    check(done_n == run_d0 + 1, "R10 single done", done_n, run_d0 + 1);
    check(got_cnt == V_N[2] && rx_n == 3, "R10 result intact", got_cnt, V_N[2]);
    check(got_err == 0 && err == 1'b0, "R8 err cleared", got_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule